// File: doc/BRIEF.md
# Timer Interrupt and Output Pin Controller

This block sits next to a pair of 8-bit down-counters that can be chained into one 16-bit counter. It receives one underflow pulse from each counter, a flag saying whether the pair runs chained, and the 2-bit interrupt mask level the CPU currently runs at. From these it keeps a latched event flag per timer and a per-timer enable bit. It also keeps one priority field that both timers share. It drives a level-sensitive interrupt request to the CPU, together with the requested level and the timer that is reported.

The block also drives a timer output pin. One underflow stream is picked by a select bit and forced to timer 1 when the counters are chained. The picked stream toggles a two-state machine: `TP_HIGH`, which is the reset state, and `TP_LOW`. The pin therefore carries a square wave at half the underflow rate. An output-enable bit decides whether the pin shows that wave or sits at a constant high level. A byte-wide register port with four addresses gives write and read access to every control bit.

The pin machine has two transitions, `HIGH_TO_LOW` and `LOW_TO_HIGH`. Each one is taken on a picked underflow pulse. Without such a pulse the machine holds its state.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0: the priority at address 0, the enables at address 1, the flags at address 2, and the pin control at address 3. At the same time `tout_o` is 1 and `irq_o` is 0.
- R2: A pulse on `uf0_i` sets flag bit 0, and a pulse on `uf1_i` sets flag bit 1. The flag is visible at address 2 from the next cycle. It is set whatever the enable and priority settings are.
- R3: A write to address 2 clears each flag whose data bit is 1 and leaves flags with a 0 bit unchanged. If an underflow and a clear reach the same flag in the same cycle, the flag ends up set.
- R4: `irq_o` is 1 exactly when a timer has its flag and its enable bit both set and the priority (address 0, bits [1:0]) is strictly greater than `cpu_mask_i`. The enables are at address 1: bit 0 is timer 0 and bit 1 is timer 1. `irq_level_o` equals the priority while `irq_o` is 1 and is 0 otherwise.
- R5: A priority of 0 never raises `irq_o`, whatever the mask, flags and enables are.
- R6: While `cascade_i` is 1, `uf0_i` does not set flag bit 0, and timer 0's enable and flag do not raise a request. A pulse on `uf1_i` sets flag bit 1.
- R7: Address 3 bit 1 is the channel select: 0 picks `uf0_i` and 1 picks `uf1_i`. While `cascade_i` is 1, `uf1_i` is picked whatever the select bit says. A pulse that is not picked leaves the pin state unchanged.
- R8: Address 3 bit 0 is the output enable. While it is 0, `tout_o` is 1. While it is 1, `tout_o` follows the pin state. That state resets high and flips on every picked underflow pulse.
- R9: When both timers request at once, `irq_src_o` is 1, which means timer 1. When only timer 0 requests, `irq_src_o` is 0.
- R10: Every writable bit reads back the value written to it. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uf0_i | input | 1 | Timer 0 underflow pulse, one cycle |
| uf1_i | input | 1 | Timer 1 (or chained 16-bit) underflow pulse, one cycle |
| cascade_i | input | 1 | 1 while the two counters run as one 16-bit counter |
| cpu_mask_i | input | LVL_W | Current CPU interrupt mask level |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Register read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request level |
| irq_level_o | output | LVL_W | Requested priority level, 0 when there is no request |
| irq_src_o | output | 1 | Reported timer: 1 for timer 1, 0 for timer 0 |
| tout_o | output | 1 | Timer output pin |

## Verification
The bench builds the block with its default parameters: `DATA_W` = 8 and `LVL_W` = 2. With a 2-bit level, every pair of priority and CPU mask can be swept exhaustively, 16 pairs in all, so each boundary of the strict greater-than comparison is checked. The bench also keeps its own model of the pin state. With that model it checks every combination of select bit, chained mode and pulse source against the pin, including pulses that must leave the pin alone.

// File: rtl/tic_pkg.sv
package tic_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_PRIO = 2'd0;
    localparam logic [ADDR_W-1:0] A_ENAB = 2'd1;
    localparam logic [ADDR_W-1:0] A_FLAG = 2'd2;
    localparam logic [ADDR_W-1:0] A_PIN  = 2'd3;
    localparam int NUM_TMR = 2;

    typedef enum logic {
        TP_HIGH = 1'b0,
        TP_LOW  = 1'b1
    } tpin_state_e;
endpackage

// File: rtl/tic_regs.sv
module tic_regs
    import tic_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LVL_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_TMR-1:0]   set_evt,
    output logic [LVL_W-1:0]     prio,
    output logic [NUM_TMR-1:0]   en,
    output logic [NUM_TMR-1:0]   flag,
    output logic                 chsel,
    output logic                 oe,
    output logic [DATA_W-1:0]    rdata
);
    logic wr_prio, wr_enab, wr_flag, wr_pin;
    logic unused_wd;

    assign unused_wd = ^wdata;
    assign wr_prio = wr_en && (addr == A_PRIO);
    assign wr_enab = wr_en && (addr == A_ENAB);
    assign wr_flag = wr_en && (addr == A_FLAG);
    assign wr_pin  = wr_en && (addr == A_PIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio  <= '0;
            en    <= '0;
            chsel <= 1'b0;
            oe    <= 1'b0;
        end else begin
            if (wr_prio) prio <= wdata[LVL_W-1:0];
            if (wr_enab) en   <= wdata[NUM_TMR-1:0];
            if (wr_pin) begin
                oe    <= wdata[0];
                chsel <= wdata[1];
            end
        end
    end

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag[i] <= 1'b0;
            else if (set_evt[i])
                flag[i] <= 1'b1;
            else if (wr_flag && wdata[i])
                flag[i] <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_PRIO: rdata[LVL_W-1:0]   = prio;
            A_ENAB: rdata[NUM_TMR-1:0] = en;
            A_FLAG: rdata[NUM_TMR-1:0] = flag;
            A_PIN:  rdata[1:0]         = {chsel, oe};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/tic_irq_arb.sv
module tic_irq_arb
    import tic_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  logic [NUM_TMR-1:0] flag,
    input  logic [NUM_TMR-1:0] en,
    input  logic               cascade,
    input  logic [LVL_W-1:0]   prio,
    input  logic [LVL_W-1:0]   mask,
    output logic               irq,
    output logic [LVL_W-1:0]   level,
    output logic               src
);
    logic [NUM_TMR-1:0] req;
    logic               above;

    assign req[0] = flag[0] && en[0] && !cascade;
    assign req[1] = flag[1] && en[1];
    assign above  = prio > mask;

    always_comb begin
        irq   = (|req) && above;
        level = irq ? prio : '0;
        src   = irq && req[1];
    end
endmodule

// File: rtl/tic_tout.sv
module tic_tout
    import tic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic uf0,
    input  logic uf1,
    input  logic cascade,
    input  logic chsel,
    input  logic oe,
    output logic pin_hi,
    output logic tout
);
    tpin_state_e state_q, state_d;
    logic        step;

    assign step = (cascade || chsel) ? uf1 : uf0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TP_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TP_HIGH: if (step) state_d = TP_LOW;
            TP_LOW:  if (step) state_d = TP_HIGH;
            default: state_d = TP_HIGH;
        endcase
    end

    always_comb begin
        pin_hi = (state_q == TP_HIGH);
        tout   = !oe || pin_hi;
    end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import tic_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LVL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uf0_i,
    input  logic              uf1_i,
    input  logic              cascade_i,
    input  logic [LVL_W-1:0]  cpu_mask_i,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic [LVL_W-1:0]  irq_level_o,
    output logic              irq_src_o,
    output logic              tout_o
);
    logic [NUM_TMR-1:0] set_w, en_w, flag_w;
    logic [LVL_W-1:0]   prio_w;
    logic               chsel_w, oe_w, pin_hi_w;

    assign set_w = {uf1_i, uf0_i && !cascade_i};

    tic_regs #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i),
        .wdata(wdata_i), .set_evt(set_w), .prio(prio_w), .en(en_w),
        .flag(flag_w), .chsel(chsel_w), .oe(oe_w), .rdata(rdata_o)
    );

    tic_irq_arb #(.LVL_W(LVL_W)) u_arb (
        .flag(flag_w), .en(en_w), .cascade(cascade_i), .prio(prio_w),
        .mask(cpu_mask_i), .irq(irq_o), .level(irq_level_o), .src(irq_src_o)
    );

    tic_tout u_tout (
        .clk(clk), .rst_n(rst_n), .uf0(uf0_i), .uf1(uf1_i),
        .cascade(cascade_i), .chsel(chsel_w), .oe(oe_w),
        .pin_hi(pin_hi_w), .tout(tout_o)
    );
endmodule

// File: rtl/tic_checker.sv
module tic_checker #(
    parameter int LVL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             uf0_i,
    input logic             uf1_i,
    input logic             cascade_i,
    input logic [LVL_W-1:0] cpu_mask_i,
    input logic             irq_o,
    input logic [LVL_W-1:0] irq_level_o,
    input logic             irq_src_o,
    input logic             tout_o,
    input logic [1:0]       flag_w,
    input logic [1:0]       en_w,
    input logic [LVL_W-1:0] prio_w,
    input logic             chsel_w,
    input logic             oe_w,
    input logic             pin_hi_w
);
    a_r2_flag1_set: assert property (@(posedge clk) disable iff (!rst_n)
        uf1_i |=> flag_w[1]);

    a_r2_flag0_set: assert property (@(posedge clk) disable iff (!rst_n)
        (uf0_i && !cascade_i) |=> flag_w[0]);

    a_r4_irq_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (prio_w > cpu_mask_i) && (irq_level_o == prio_w));

    a_r5_prio0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_w == '0) |-> !irq_o);

    a_r6_flag0_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_i && !flag_w[0]) |=> !flag_w[0]);

    a_r6_t0_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_i && !(flag_w[1] && en_w[1])) |-> !irq_o);

    a_r7_cascade_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_i && !uf1_i) |=> $stable(pin_hi_w));

    a_r8_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_w |-> tout_o);

    a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ((cascade_i || chsel_w) ? uf1_i : uf0_i) |=> (pin_hi_w != $past(pin_hi_w)));

    a_r9_t1_first: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && flag_w[1] && en_w[1]) |-> irq_src_o);
endmodule

bind tmr_irq_ctrl tic_checker #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .uf0_i(uf0_i), .uf1_i(uf1_i),
    .cascade_i(cascade_i), .cpu_mask_i(cpu_mask_i), .irq_o(irq_o),
    .irq_level_o(irq_level_o), .irq_src_o(irq_src_o), .tout_o(tout_o),
    .flag_w(flag_w), .en_w(en_w), .prio_w(prio_w), .chsel_w(chsel_w),
    .oe_w(oe_w), .pin_hi_w(pin_hi_w)
);

// File: tb/tmr_irq_ctrl_bench.sv
module tmr_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int LVL_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              uf0_i = 1'b0, uf1_i = 1'b0, cascade_i = 1'b0;
    logic [LVL_W-1:0]  cpu_mask_i = '0;
    logic              wr_en_i = 1'b0;
    logic [1:0]        addr_i = '0;
    logic [DATA_W-1:0] wdata_i = '0;
    logic [DATA_W-1:0] rdata_o;
    logic              irq_o, irq_src_o, tout_o;
    logic [LVL_W-1:0]  irq_level_o;

    int  n_chk = 0, n_fail = 0;
    logic pin_model = 1'b1;
    logic sel_model = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_irq_ctrl #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_tmr_irq_ctrl (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wdata_i = '0;
        if (a == 2'd3) sel_model = d[1];
    endtask

    task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic pulse(input logic p0, input logic p1);
        logic picked;
        @(negedge clk);
        uf0_i = p0; uf1_i = p1;
        picked = (cascade_i || sel_model) ? p1 : p0;
        @(negedge clk);
        uf0_i = 1'b0; uf1_i = 1'b0;
        if (picked) pin_model = ~pin_model;
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            check("R1 register reset", d, 0);
        end
        check("R1 tout reset", tout_o, 1);
        check("R1 irq reset", irq_o, 0);
    endtask

    task automatic t_readback();
        logic [DATA_W-1:0] d;
        wr(2'd0, 8'hFF); rd(2'd0, d); check("R10 prio readback", d, 8'h03);
        wr(2'd1, 8'hFE); rd(2'd1, d); check("R10 enable readback", d, 8'h02);
        wr(2'd3, 8'hFE); rd(2'd3, d); check("R10 pin ctrl readback", d, 8'h02);
        wr(2'd0, 0); wr(2'd1, 0); wr(2'd3, 0);
    endtask

    task automatic t_flag_set();
        logic [DATA_W-1:0] d;
        pulse(1, 0); rd(2'd2, d); check("R2 flag0 set with enable off", d, 8'h01);
        check("R2 no irq while disabled", irq_o, 0);
        pulse(0, 1); rd(2'd2, d); check("R2 flag1 set", d, 8'h03);
    endtask

    task automatic t_clear();
        logic [DATA_W-1:0] d;
        wr(2'd2, 8'h00); rd(2'd2, d); check("R3 write 0 keeps flags", d, 8'h03);
        wr(2'd2, 8'h01); rd(2'd2, d); check("R3 clear flag0 only", d, 8'h02);
        wr(2'd2, 8'h02); rd(2'd2, d); check("R3 clear flag1", d, 8'h00);
        @(negedge clk);
        uf0_i = 1'b1; wr_en_i = 1'b1; addr_i = 2'd2; wdata_i = 8'h01;
        if (!sel_model) pin_model = ~pin_model;
        @(negedge clk);
        uf0_i = 1'b0; wr_en_i = 1'b0; wdata_i = '0;
        rd(2'd2, d); check("R3 set wins over clear", d, 8'h01);
        wr(2'd2, 8'h03);
    endtask

    task automatic t_levels();
        wr(2'd1, 8'h02); pulse(0, 1);
        for (int p = 0; p < 4; p++) begin
            wr(2'd0, p[7:0]);
            for (int m = 0; m < 4; m++) begin
                cpu_mask_i = m[1:0];
                #1;
                check("R4 irq vs mask", irq_o, (p > m) ? 1 : 0);
                check("R4 irq level", irq_level_o, (p > m) ? p : 0);
                if (p == 0) check("R5 prio 0 never requests", irq_o, 0);
            end
        end
        cpu_mask_i = 0;
        wr(2'd1, 8'h00); check("R4 enable off blocks irq", irq_o, 0);
        wr(2'd2, 8'h03);
    endtask

    task automatic t_both();
        wr(2'd1, 8'h03); wr(2'd0, 8'h02);
        pulse(1, 1);
        check("R9 both requesting", irq_o, 1);
        check("R9 timer1 reported first", irq_src_o, 1);
        wr(2'd2, 8'h02);
        check("R9 timer0 alone", irq_src_o, 0);
        check("R4 timer0 still requests", irq_o, 1);
        wr(2'd2, 8'h03);
    endtask

    task automatic t_cascade();
        logic [DATA_W-1:0] d;
        pulse(1, 0);
        cascade_i = 1'b1; #1;
        check("R6 timer0 enable ignored when chained", irq_o, 0);
        wr(2'd2, 8'h01);
        pulse(1, 0); rd(2'd2, d); check("R6 flag0 not set when chained", d, 8'h00);
        pulse(0, 1); rd(2'd2, d); check("R6 chained underflow sets flag1", d, 8'h02);
        check("R6 chained irq from timer1", irq_o, 1);
        cascade_i = 1'b0;
        wr(2'd2, 8'h03); wr(2'd1, 0); wr(2'd0, 0);
    endtask

    task automatic t_tout();
        wr(2'd3, 8'h00);
        pulse(1, 0); check("R8 pin high while disabled", tout_o, 1);
        wr(2'd3, 8'h01);
        check("R8 pin shows state", tout_o, pin_model);
        pulse(0, 1); check("R7 unpicked uf1 ignored", tout_o, pin_model);
        pulse(1, 0); check("R8 toggle on uf0", tout_o, pin_model);
        pulse(1, 0); check("R8 toggle again", tout_o, pin_model);
        wr(2'd3, 8'h03);
        pulse(1, 0); check("R7 unpicked uf0 ignored", tout_o, pin_model);
        pulse(0, 1); check("R7 select picks uf1", tout_o, pin_model);
        wr(2'd3, 8'h01); cascade_i = 1'b1;
        pulse(1, 0); check("R7 chained ignores uf0", tout_o, pin_model);
        pulse(0, 1); check("R7 chained forces uf1", tout_o, pin_model);
        cascade_i = 1'b0;
        wr(2'd2, 8'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_flag_set();
        t_clear();
        t_levels();
        t_both();
        t_cascade();
        t_tout();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule